// File: doc/BRIEF.md
# Watchdog Timer with Unlock-Sequence Reload

This block is a memory-mapped watchdog. Software talks to it through a single-cycle register port: a 4-bit byte address, 32-bit write data, a write strobe, and combinational read data. The timebase comes from a watchdog clock, given as a one-cycle enable pulse in the bus clock domain. A fixed divide-by-4 prescaler turns those pulses into ticks. Each tick decrements a 24-bit down-counter. When the counter runs out, the block raises a one-cycle reset request.

The counter is reloaded only by a two-write unlock on the feed register: 0xAA, then 0x55 as the next bus write. The same sequence arms the watchdog, but only if the enable bit is already set. Once armed, the watchdog cannot be disarmed and its mode bits cannot be cleared. On an armed watchdog, a broken unlock sequence requests a reset at once. A sticky flag records that a reset request was made, and it survives until the bus reset.

Register layout (byte offsets): 0x0 control, 0x4 reload value, 0x8 unlock, 0xC live count (read-only). Control bits: bit 0 enable, bit 1 reset-enable, bit 2 timeout flag (read-only).

Top module: `wdt_guard`

## Requirements
- R1: After rst_n is released, control reads 0, the reload value reads 0x0000FF, the live count reads 0x0000FF and wd_reset is low.
- R2: A write to offset 0x4 stores wdata[23:0], except that any value below 0xFF is stored as 0xFF. The stored value reads back at 0x4.
- R3: A write of 0xAA to offset 0x8, followed by a write of 0x55 to offset 0x8 as the next write strobe, loads the live count from the reload value. Idle cycles between the two writes are allowed. Offset 0x8 reads 0.
- R4: The watchdog becomes armed only when the 0x55 write of a valid unlock completes while control bit 0 is set. Until then the live count does not move on watchdog clock pulses.
- R5: While armed, the live count decrements by one on every fourth wclk_en pulse counted from the last valid unlock.
- R6: While armed with bit 1 set, a tick that finds the count at 0 raises wd_reset for exactly one cycle and reloads the count from the reload value.
- R7: Before arming, a control write sets bits 1:0 to wdata[1:0]. After arming, a control write can only set those bits, never clear them.
- R8: On an armed watchdog, a pending 0xAA followed by any write other than 0x55 to offset 0x8 raises wd_reset for one cycle in the cycle after that write, and reloads the count.
- R9: On a watchdog that is not armed, a broken unlock sequence raises no reset and leaves the live count unchanged.
- R10: Every wd_reset pulse sets control bit 2. The bit stays set until rst_n.
- R11: While armed with bit 1 clear, expiry raises no reset and only reloads the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wclk_en | input | 1 | One-cycle pulse per watchdog clock edge |
| addr | input | 4 | Register byte offset |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_data | output | 32 | Read data for addr |
| wd_reset | output | 1 | One-cycle reset request |

## Verification
The reload-value clamp is tried with a table of values below, at and above the 0xFF floor, including values whose upper byte must be dropped. The unlock logic is tried with four patterns: a correct pair with idle gaps, 0xAA twice, 0xAA followed by a write to another register, and broken pairs on an unarmed watchdog. Together these separate reload, abort and arming. The counting path is tried with partial groups of pulses, which shows the divide-by-4 boundary. It is also run to full expiry with reset-enable on and with it off, which separates expiry from the reset request.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_RELD  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_KEY   = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 4'hC;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  typedef struct packed {
    logic flag;
    logic rst_en;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  input  logic pulse,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  assign tick = run && pulse && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (run && pulse)
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_key_check.sv
module wdt_key_check
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       is_key,
  input  logic [7:0] wbyte,
  output logic       key_ok,
  output logic       key_bad
);
  logic pend_q, pend_d;

  assign key_ok  = wr_en && pend_q && is_key && (wbyte == KEY_SECOND);
  assign key_bad = wr_en && pend_q && !key_ok;

  always_comb begin
    pend_d = pend_q;
    if (wr_en)
      pend_d = !pend_q && is_key && (wbyte == KEY_FIRST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/wdt_down_count.sv
module wdt_down_count #(
  parameter int unsigned         CNT_W   = 24,
  parameter logic [CNT_W-1:0]    RST_VAL = 24'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign count  = cnt_q;
  assign expire = tick && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = load_val;
    else if (tick) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned DIV      = 4,
  parameter int unsigned RELD_MIN = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wclk_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              wd_reset
);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(RELD_MIN);

  ctrl_t            ctrl_q, ctrl_d;
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] reld_q, reld_d;
  logic             rst_q;
  logic             tick, key_ok, key_bad, expire, fire, load;
  logic [CNT_W-1:0] count;

  wire wr_ctrl = wr_en && (addr == OFS_CTRL);
  wire wr_reld = wr_en && (addr == OFS_RELD);
  wire is_key  = (addr == OFS_KEY);

  wdt_key_check u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .is_key(is_key),
    .wbyte(wdata[7:0]), .key_ok(key_ok), .key_bad(key_bad)
  );

  wdt_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(armed_q), .clr(key_ok),
    .pulse(wclk_en), .tick(tick)
  );

  assign fire = (armed_q && key_bad) || (expire && ctrl_q.rst_en);
  assign load = key_ok || fire || expire;

  wdt_down_count #(.CNT_W(CNT_W), .RST_VAL(FLOOR)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
    .load_val(reld_q), .count(count), .expire(expire)
  );

  always_comb begin
    ctrl_d  = ctrl_q;
    armed_d = armed_q || (key_ok && ctrl_q.en);
    reld_d  = reld_q;
    if (wr_ctrl) begin
      if (armed_q) begin
        ctrl_d.en     = ctrl_q.en     | wdata[0];
        ctrl_d.rst_en = ctrl_q.rst_en | wdata[1];
      end else begin
        ctrl_d.en     = wdata[0];
        ctrl_d.rst_en = wdata[1];
      end
    end
    if (fire) ctrl_d.flag = 1'b1;
    if (wr_reld)
      reld_d = (wdata[CNT_W-1:0] < FLOOR) ? FLOOR : wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      armed_q <= 1'b0;
      reld_q  <= FLOOR;
      rst_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      armed_q <= armed_d;
      reld_q  <= reld_d;
      rst_q   <= fire;
    end
  end

  assign wd_reset = rst_q;

  always_comb begin
    unique case (addr)
      OFS_CTRL:  rd_data = DATA_W'({ctrl_q.flag, ctrl_q.rst_en, ctrl_q.en});
      OFS_RELD:  rd_data = DATA_W'(reld_q);
      OFS_COUNT: rd_data = DATA_W'(count);
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned RELD_MIN = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wd_reset,
  input logic             armed,
  input logic             en,
  input logic             rst_en,
  input logic             flag,
  input logic [CNT_W-1:0] reld
);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |=> !wd_reset);
  a_r10_flag_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |-> flag);
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> flag);
  a_r7_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> (armed && en));
  a_r7_rsten_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rst_en) |=> rst_en);
  a_r4_arm_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> en);
  a_r2_floor: assert property (@(posedge clk) disable iff (!rst_n)
    reld >= CNT_W'(RELD_MIN));
endmodule

bind wdt_guard wdt_guard_chk #(.CNT_W(CNT_W), .RELD_MIN(RELD_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wd_reset(wd_reset), .armed(armed_q),
  .en(ctrl_q.en), .rst_en(ctrl_q.rst_en), .flag(ctrl_q.flag), .reld(reld_q)
);

// File: tb/tb_wdt_guard.sv
module tb_wdt_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wclk_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic [31:0] rd_data;
  logic        wd_reset;

  int checks = 0;
  int errors = 0;
  int pulses_seen = 0;
  bit done = 1'b0;

  wdt_guard dut (.clk(clk), .rst_n(rst_n), .wclk_en(wclk_en), .addr(addr),
                 .wdata(wdata), .wr_en(wr_en), .rd_data(rd_data), .wd_reset(wd_reset));

  always #10 clk = ~clk;

  always @(negedge clk) if (wd_reset) pulses_seen++;

  localparam int NV = 8;
  localparam logic [31:0] VEC_IN  [NV] = '{32'h0, 32'h10, 32'hFE, 32'hFF,
                                          32'h100, 32'hFFFFFF, 32'h01234567, 32'h01000005};
  localparam logic [31:0] VEC_EXP [NV] = '{32'hFF, 32'hFF, 32'hFF, 32'hFF,
                                          32'h100, 32'hFFFFFF, 32'h234567, 32'hFF};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wclk_en = 1'b1;
      @(negedge clk); wclk_en = 1'b0;
    end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'h0, v); chk("R1 ctrl", v, 32'h0);
    rd(4'h4, v); chk("R1 reload", v, 32'hFF);
    rd(4'hC, v); chk("R1 count", v, 32'hFF);
    chk("R1 wd_reset", {31'b0, wd_reset}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(4'h4, VEC_IN[i]);
      rd(4'h4, v); chk("R2 clamp", v, VEC_EXP[i]);
    end

    wr(4'h4, 32'h100);
    wr(4'h8, 32'hAA); repeat (2) @(negedge clk); wr(4'h8, 32'h55);
    rd(4'hC, v); chk("R3 reload", v, 32'h100);
    rd(4'h8, v); chk("R3 key reads 0", v, 32'h0);

    wr(4'h4, 32'h180);
    wr(4'h8, 32'hAA); wr(4'h8, 32'hAA);
    rd(4'hC, v); chk("R9 count kept", v, 32'h100);
    wr(4'h8, 32'hAA); wr(4'h0, 32'h0);
    rd(4'hC, v); chk("R9 count kept other reg", v, 32'h100);
    repeat (2) @(negedge clk);
    chk("R9 no reset", pulses_seen, 0);
    wr(4'h4, 32'h100);

    wr(4'h0, 32'h1); pulse(8);
    rd(4'hC, v); chk("R4 not armed", v, 32'h100);
    wr(4'h0, 32'h0);
    rd(4'h0, v); chk("R7 clear before arm", v, 32'h0);

    wr(4'h0, 32'h3);
    wr(4'h8, 32'hAA); @(negedge clk); wr(4'h8, 32'h55);
    pulse(8);
    rd(4'hC, v); chk("R5 two ticks", v, 32'hFE);
    pulse(3);
    rd(4'hC, v); chk("R5 partial group", v, 32'hFE);
    pulse(1);
    rd(4'hC, v); chk("R5 third tick", v, 32'hFD);

    wr(4'h0, 32'h0);
    rd(4'h0, v); chk("R7 armed ignores clear", v[1:0], 32'h3);

    wr(4'h8, 32'hAA); wr(4'h4, 32'h100);
    repeat (2) @(negedge clk);
    chk("R8 abort by other write", pulses_seen, 1);
    rd(4'h0, v); chk("R10 flag set", v, 32'h7);
    rd(4'hC, v); chk("R8 count reloaded", v, 32'h100);
    wr(4'h8, 32'hAA); wr(4'h8, 32'hAA);
    repeat (2) @(negedge clk);
    chk("R8 AA then AA", pulses_seen, 2);

    wr(4'h8, 32'hAA); wr(4'h8, 32'h55);
    base = pulses_seen;
    pulse(1027);
    chk("R6 not yet", pulses_seen, base);
    pulse(1);
    @(negedge clk);
    chk("R6 single pulse", pulses_seen, base + 1);
    rd(4'hC, v); chk("R6 reload", v, 32'h100);
    rd(4'h0, v); chk("R10 flag still set", v, 32'h7);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd(4'h0, v); chk("R10 flag cleared by reset", v, 32'h0);

    wr(4'h0, 32'h1);
    wr(4'h8, 32'hAA); wr(4'h8, 32'h55);
    base = pulses_seen;
    pulse(1020);
    rd(4'hC, v); chk("R11 reached zero", v, 32'h0);
    pulse(4);
    @(negedge clk);
    chk("R11 no reset", pulses_seen, base);
    rd(4'hC, v); chk("R11 reload", v, 32'hFF);
    rd(4'h0, v); chk("R11 flag clear", v, 32'h1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule